// File: doc/BRIEF.md
# Segmented-Fabric Routing Switch Block

This block models the programmable switch that sits where four routing channels cross (north, east, south, west) in a fabric built from wire segments of length `S`. Each side carries `W` tracks. The model is one-directional: every side has `W` incoming and `W` outgoing track signals.

At this crossing some tracks have a segment that finishes here, and the rest run on through it. The stagger of segment starts decides which tracks finish. Tracks that finish here are joined by a rotated turn pattern. Their index is remapped when a net turns a corner, and goes straight across unchanged. Tracks that run on are wired straight across by default. A two-bit field can instead turn them onto a perpendicular side, and the index is always kept. The result is `S` separate routing domains: one for each track residue modulo `S`.

A flat configuration vector holds one two-bit field per outgoing track. The block decodes these fields, routes the incoming values, and raises a flag when a field asks for two drivers at once. Outputs and the flag are registered, so they appear one clock after the inputs are presented.

Top module: `sb_switch_block`

## Requirements
- R1: While `rst_n` is low, every bit of `track_out` and `config_error` reads 0 after the next rising edge. Otherwise each rising edge captures `track_out` and `config_error` from the `track_in` and `cfg` values present at that edge, so the results show one cycle later.
- R2: Side numbers are north 0, east 1, south 2, west 3. Track `t` of side `b` is bit `b*W+t` of `track_in` and of `track_out`. Track `t` finishes at this block exactly when `(t+OFFSET) mod S == 0`. The finishing tracks all share one residue `r0`, and finishing track `t` has rank `k = t/S`, with `M = W/S` ranks.
- R3: Outgoing track `t` of side `b` uses the field `cfg[2*(b*W+t)+1 : 2*(b*W+t)]`. For a track that runs on, code 00 drives it from incoming track `t` of the opposite side `(b+2) mod 4`.
- R4: For a track that runs on, code 01 drives it from incoming track `t` of side `(b+1) mod 4`, and code 10 drives it from incoming track `t` of side `(b+3) mod 4`. No setting of these codes moves a value to a different track index.
- R5: For a track that runs on, code 11 requests two drivers at once. That outgoing track reads 0 and `config_error` reads 1. `config_error` reads 0 whenever no such field is present.
- R6: For a finishing track, code 0 leaves it undriven (it reads 0), and code 2 drives it from incoming track `t` of the opposite side.
- R7: For a finishing track of rank `j` on side `b`, code 1 selects source side `a=(b+1) mod 4` and code 3 selects `a=(b+3) mod 4`. The source is the finishing track of rank `f(b→a, j)`, taken modulo `M`. The map is: west→north `M−i`, north→west `M−i`, north→east `i+1`, east→north `i−1`, east→south `M−2−i`, south→east `M−2−i`, south→west `i−1`, west→south `i+1`.
- R8: Each incoming finishing track can be selected by exactly one outgoing finishing track on each of the other three sides, giving a flexibility of three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| track_in | input | 4*W | Incoming track values, side-major |
| cfg | input | 8*W | Two-bit source field per outgoing track |
| track_out | output | 4*W | Registered outgoing track values |
| config_error | output | 1 | Registered flag: some field of a track that runs on requests two drivers |

## Verification
The assertions assume that `cfg` and `track_in` hold steady around each rising edge. They also assume the clock keeps running while reset is low, so that the cycle after reset release can be related to the cycle before it. The bench changes all inputs only on falling edges and holds reset low for several cycles, so both conditions hold. Its configurations mix fixed code sets that isolate each field meaning, random legal codes, deliberate double-driver codes, and single-hot incoming patterns. The single-hot patterns show each turn map and the three-way fan-out of finishing tracks.

// File: rtl/sb_pkg.sv
// Shared constants and compile-time helpers for the segmented switch block.
// Assumes sides are numbered clockwise starting at north, and OFFSET >= 0.
package sb_pkg;
    localparam int SIDE_N = 0;
    localparam int SIDE_E = 1;
    localparam int SIDE_S = 2;
    localparam int SIDE_W = 3;
    localparam int NSIDES = 4;

    // True when track t finishes its segment at this crossing.
    function automatic bit track_ends(int t, int seg, int offs);
        return ((t + offs) % seg) == 0;
    endfunction

    // Index of the lowest finishing track.
    function automatic int first_end(int seg, int offs);
        return (seg - (offs % seg)) % seg;
    endfunction

    // Non-negative modulo.
    function automatic int wrap(int x, int m);
        return ((x % m) + m) % m;
    endfunction

    // Rank reached on side 'to' by a finishing track of rank i entering on side 'from'.
    function automatic int turn_rank(int from, int to, int i, int m);
        int r;
        if ((from == SIDE_W && to == SIDE_N) || (from == SIDE_N && to == SIDE_W))
            r = m - i;
        else if (from == SIDE_N && to == SIDE_E)
            r = i + 1;
        else if (from == SIDE_E && to == SIDE_N)
            r = i - 1;
        else if ((from == SIDE_E && to == SIDE_S) || (from == SIDE_S && to == SIDE_E))
            r = m - 2 - i;
        else if (from == SIDE_S && to == SIDE_W)
            r = i - 1;
        else if (from == SIDE_W && to == SIDE_S)
            r = i + 1;
        else
            r = i;
        return wrap(r, m);
    endfunction
endpackage

// File: rtl/sb_end_mux.sv
// Source selector for one outgoing finishing track.
// Code 0 leaves the track undriven (0); codes 1..3 pick the source side
// rotated clockwise by that many sides. The source wiring is fixed by the parent.
module sb_end_mux (
    input  logic [1:0] sel,
    input  logic       src_cw,
    input  logic       src_opp,
    input  logic       src_ccw,
    output logic       out
);
    // Decode the select code onto one of three fixed sources.
    always_comb begin
        unique case (sel)
            2'd1:    out = src_cw;
            2'd2:    out = src_opp;
            2'd3:    out = src_ccw;
            default: out = 1'b0;
        endcase
    end
endmodule

// File: rtl/sb_pass_mux.sv
// Source selector for one outgoing track that runs on through the crossing.
// Default is straight across. Each turn source has its own enable bit. Both
// enables at once request two drivers: the output is forced to 0 and a conflict is reported.
module sb_pass_mux (
    input  logic [1:0] turn_en,
    input  logic       src_opp,
    input  logic       src_cw,
    input  logic       src_ccw,
    output logic       out,
    output logic       conflict
);
    // Pick the straight or turned same-index driver.
    always_comb begin
        conflict = 1'b0;
        unique case (turn_en)
            2'b00: out = src_opp;
            2'b01: out = src_cw;
            2'b10: out = src_ccw;
            default: begin
                out      = 1'b0;
                conflict = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sb_out_stage.sv
// Output register for the routed tracks and the configuration flag.
// Synchronous, active-low reset clears all state.
module sb_out_stage #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    input  logic         err_d,
    output logic [N-1:0] q,
    output logic         err_q
);
    // Capture routed values and flag each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            err_q <= 1'b0;
        end else begin
            q     <= d;
            err_q <= err_d;
        end
    end
endmodule

// File: rtl/sb_switch_block.sv
// Switch block for a segmented routing fabric with four channels of W tracks.
// Finishing tracks ((t+OFFSET) mod S == 0) use a rotated turn pattern, and the
// other tracks keep their index. Outputs are registered.
// Assumes W is a multiple of S, S >= 1 and OFFSET >= 0.
module sb_switch_block #(
    parameter int W      = 16,
    parameter int S      = 4,
    parameter int OFFSET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4*W-1:0]   track_in,
    input  logic [8*W-1:0]   cfg,
    output logic [4*W-1:0]   track_out,
    output logic             config_error
);
    import sb_pkg::*;

    localparam int TW = NSIDES * W;
    localparam int M  = W / S;
    localparam int R0 = first_end(S, OFFSET);

    logic [TW-1:0] routed;
    logic [TW-1:0] conflict;

    for (genvar gb = 0; gb < NSIDES; gb++) begin : g_side
        localparam int CWS  = (gb + 1) % NSIDES;
        localparam int OPS  = (gb + 2) % NSIDES;
        localparam int CCWS = (gb + 3) % NSIDES;
        for (genvar gt = 0; gt < W; gt++) begin : g_trk
            localparam int IDX = gb * W + gt;
            if (track_ends(gt, S, OFFSET)) begin : g_end
                localparam int K     = gt / S;
                localparam int T_CW  = R0 + S * turn_rank(gb, CWS, K, M);
                localparam int T_CCW = R0 + S * turn_rank(gb, CCWS, K, M);
                sb_end_mux u_mux (
                    .sel     (cfg[2*IDX +: 2]),
                    .src_cw  (track_in[CWS*W + T_CW]),
                    .src_opp (track_in[OPS*W + gt]),
                    .src_ccw (track_in[CCWS*W + T_CCW]),
                    .out     (routed[IDX])
                );
                assign conflict[IDX] = 1'b0;
            end else begin : g_pass
                sb_pass_mux u_mux (
                    .turn_en  (cfg[2*IDX +: 2]),
                    .src_opp  (track_in[OPS*W + gt]),
                    .src_cw   (track_in[CWS*W + gt]),
                    .src_ccw  (track_in[CCWS*W + gt]),
                    .out      (routed[IDX]),
                    .conflict (conflict[IDX])
                );
            end
        end
    end

    sb_out_stage #(.N(TW)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (routed),
        .err_d (|conflict),
        .q     (track_out),
        .err_q (config_error)
    );
endmodule

// File: rtl/sb_switch_block_chk.sv
// Assertion checker for sb_switch_block, attached by bind below.
// Relates registered outputs to the inputs of the previous cycle.
module sb_switch_block_chk #(
    parameter int W      = 16,
    parameter int S      = 4,
    parameter int OFFSET = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [4*W-1:0] track_in,
    input logic [8*W-1:0] cfg,
    input logic [4*W-1:0] track_out,
    input logic           config_error
);
    import sb_pkg::*;

    logic any_double;

    // Flag any field of a track that runs on that enables both turns.
    always_comb begin
        any_double = 1'b0;
        for (int b = 0; b < NSIDES; b++)
            for (int t = 0; t < W; t++)
                if (!track_ends(t, S, OFFSET) && cfg[2*(b*W+t) +: 2] == 2'b11)
                    any_double = 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (track_out == '0 && !config_error));

    p_error_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (config_error == $past(any_double)));

    for (genvar gb = 0; gb < NSIDES; gb++) begin : g_side
        localparam int OPS = (gb + 2) % NSIDES;
        localparam int CWS = (gb + 1) % NSIDES;
        localparam int CCS = (gb + 3) % NSIDES;
        for (genvar gt = 0; gt < W; gt++) begin : g_trk
            localparam int IDX = gb * W + gt;
            if (track_ends(gt, S, OFFSET)) begin : g_end
                p_end_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && $past(cfg[2*IDX +: 2]) == 2'd0) |-> !track_out[IDX]);
                p_end_straight_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && $past(cfg[2*IDX +: 2]) == 2'd2)
                    |-> (track_out[IDX] == $past(track_in[OPS*W + gt])));
            end else begin : g_pass
                p_pass_straight_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && $past(cfg[2*IDX +: 2]) == 2'b00)
                    |-> (track_out[IDX] == $past(track_in[OPS*W + gt])));
                p_pass_domain_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(rst_n) && track_out[IDX])
                    |-> $past(track_in[OPS*W + gt] | track_in[CWS*W + gt] | track_in[CCS*W + gt]));
            end
        end
    end
endmodule

bind sb_switch_block sb_switch_block_chk #(.W(W), .S(S), .OFFSET(OFFSET)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .track_in     (track_in),
    .cfg          (cfg),
    .track_out    (track_out),
    .config_error (config_error)
);

// File: tb/sb_switch_block_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares them one edge later.
module sb_switch_block_tb;
    localparam int W   = 16;
    localparam int S   = 4;
    localparam int OFF = 1;
    localparam int TW  = 4 * W;
    localparam int CW  = 8 * W;
    localparam int M   = W / S;
    localparam int R0  = (S - (OFF % S)) % S;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] track_in = '0;
    logic [CW-1:0] cfg = '0;
    logic [TW-1:0] track_out;
    logic          config_error;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [TW-1:0] exp_out;
        logic          exp_err;
        string         tag;
    } item_t;
    item_t sbq[$];

    sb_switch_block #(.W(W), .S(S), .OFFSET(OFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .track_in(track_in), .cfg(cfg),
        .track_out(track_out), .config_error(config_error)
    );

    always #10 clk = ~clk;

    function automatic bit ends(int t);
        return ((t + OFF) % S) == 0;
    endfunction

    function automatic int md(int x);
        return ((x % M) + M) % M;
    endfunction

    // Turn map from R7, written from the requirement.
    function automatic int rk(int from, int to, int i);
        if ((from == 3 && to == 0) || (from == 0 && to == 3)) return md(M - i);
        if (from == 0 && to == 1) return md(i + 1);
        if (from == 1 && to == 0) return md(i - 1);
        if ((from == 1 && to == 2) || (from == 2 && to == 1)) return md(M - 2 - i);
        if (from == 2 && to == 3) return md(i - 1);
        if (from == 3 && to == 2) return md(i + 1);
        return i;
    endfunction

    // Expected outputs from R2..R7.
    task automatic model(input logic [TW-1:0] tin, input logic [CW-1:0] c,
                         output logic [TW-1:0] o, output logic e);
        o = '0;
        e = 1'b0;
        for (int b = 0; b < 4; b++) begin
            for (int t = 0; t < W; t++) begin
                logic [1:0] code;
                int a;
                code = c[2*(b*W+t) +: 2];
                if (ends(t)) begin
                    if (code == 2'd2) o[b*W+t] = tin[((b+2)%4)*W + t];
                    else if (code != 2'd0) begin
                        a = (b + int'(code)) % 4;
                        o[b*W+t] = tin[a*W + R0 + S*rk(b, a, t/S)];
                    end
                end else begin
                    case (code)
                        2'b00: o[b*W+t] = tin[((b+2)%4)*W + t];
                        2'b01: o[b*W+t] = tin[((b+1)%4)*W + t];
                        2'b10: o[b*W+t] = tin[((b+3)%4)*W + t];
                        default: e = 1'b1;
                    endcase
                end
            end
        end
    endtask

    // endpol: 0 all 0, 1 all 2, 2 random 0..3, 3 random 1 or 3.
    // passpol: 0 all 00, 1 random 01/10, 2 random 00..11, 3 random 00..10.
    function automatic logic [CW-1:0] mk_cfg(int endpol, int passpol);
        logic [CW-1:0] c;
        for (int b = 0; b < 4; b++)
            for (int t = 0; t < W; t++) begin
                logic [1:0] v;
                if (ends(t)) begin
                    case (endpol)
                        0: v = 2'd0;
                        1: v = 2'd2;
                        2: v = 2'($urandom_range(3));
                        default: v = ($urandom_range(1) != 0) ? 2'd1 : 2'd3;
                    endcase
                end else begin
                    case (passpol)
                        0: v = 2'b00;
                        1: v = ($urandom_range(1) != 0) ? 2'b01 : 2'b10;
                        2: v = 2'($urandom_range(3));
                        default: v = 2'($urandom_range(2));
                    endcase
                end
                c[2*(b*W+t) +: 2] = v;
            end
        return c;
    endfunction

    function automatic logic [TW-1:0] rnd_in();
        logic [TW-1:0] v;
        for (int i = 0; i < TW; i += 32) v[i +: 32] = $urandom();
        return v;
    endfunction

    // Driver: present inputs on a falling edge and queue the expected result.
    task automatic apply(input logic [TW-1:0] tin, input logic [CW-1:0] c, input string tag);
        item_t it;
        @(negedge clk);
        track_in = tin;
        cfg = c;
        if (!rst_n) begin
            it.exp_out = '0;
            it.exp_err = 1'b0;
        end else model(tin, c, it.exp_out, it.exp_err);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare just after the edge that registered the queued inputs.
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (track_out !== it.exp_out) begin
                errors++;
                $display("FAIL %s track_out got %h exp %h", it.tag, track_out, it.exp_out);
            end
            checks++;
            if (config_error !== it.exp_err) begin
                errors++;
                $display("FAIL %s config_error got %b exp %b", it.tag, config_error, it.exp_err);
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs held clear during reset despite active inputs.
        for (int i = 0; i < 4; i++) apply(rnd_in(), mk_cfg(2, 2), "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: finishing tracks undriven, others straight: shows which tracks finish.
        for (int i = 0; i < 6; i++) apply(rnd_in(), mk_cfg(0, 0), "R2 classify");
        apply('1, mk_cfg(0, 0), "R2 classify all-ones");
        // R3: straight default for tracks that run on.
        for (int i = 0; i < 6; i++) apply(rnd_in(), mk_cfg(1, 0), "R3 straight");
        // R4: same-index turns only, finishing tracks undriven.
        for (int i = 0; i < 10; i++) apply(rnd_in(), mk_cfg(0, 1), "R4 turn");
        for (int b = 0; b < 4; b++)
            for (int t = 0; t < W; t++)
                if (!ends(t)) begin
                    logic [TW-1:0] one;
                    one = '0;
                    one[b*W+t] = 1'b1;
                    apply(one, mk_cfg(0, 3), "R4 domain single-hot");
                end
        // R5: double-driver codes.
        for (int i = 0; i < 8; i++) apply(rnd_in(), mk_cfg(2, 2), "R5 conflict");
        begin
            logic [CW-1:0] c;
            c = mk_cfg(1, 0);
            c[2*(2*W+0) +: 2] = 2'b11;
            apply('1, c, "R5 single conflict");
            apply('1, mk_cfg(1, 0), "R5 conflict cleared");
        end
        // R6: undriven or straight finishing tracks.
        for (int i = 0; i < 6; i++) apply(rnd_in(), mk_cfg(1, 3), "R6 straight");
        apply('1, mk_cfg(0, 3), "R6 undriven");
        // R7: rotated turns of finishing tracks.
        for (int i = 0; i < 12; i++) apply(rnd_in(), mk_cfg(3, 3), "R7 rotate");
        // R8: each incoming finishing track reaches one track on each other side.
        for (int a = 0; a < 4; a++)
            for (int k = 0; k < M; k++) begin
                logic [TW-1:0] one;
                logic [CW-1:0] c;
                one = '0;
                one[a*W + R0 + S*k] = 1'b1;
                c = mk_cfg(0, 0);
                for (int b = 0; b < 4; b++)
                    for (int t = 0; t < W; t++)
                        if (ends(t) && b != a) c[2*(b*W+t) +: 2] = 2'((a - b + 4) % 4);
                apply(one, c, "R8 fanout");
                @(posedge clk);
                #3;
                for (int b = 0; b < 4; b++) begin
                    int exp_cnt;
                    exp_cnt = (b == a) ? 0 : 1;
                    checks++;
                    if ($countones(track_out[b*W +: W]) != exp_cnt) begin
                        errors++;
                        $display("FAIL R8 side %0d count got %0d exp %0d", b,
                                 $countones(track_out[b*W +: W]), exp_cnt);
                    end
                end
            end
        // Mixed random configurations across R3..R7.
        for (int i = 0; i < 40; i++) apply(rnd_in(), mk_cfg(2, 3), "R7 mixed");
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule